// File: doc/BRIEF.md
# Three-Phase Imbalance Detector

This block watches three signed phase samples and reports when they no longer form a balanced set. The three samples of a healthy three-phase system add up to zero. A broken or unequal phase leaves a common-mode residue, called the homopolar quantity. The block forms that sum on every accepted sample. It passes the sum through a first-order low-pass filter whose time constant is set by a shift value. It then compares the magnitude of the filtered sum against three times a programmable reference threshold.

The filter exists for one reason. A single lost phase reads zero near the angles where its own waveform crosses zero, so the raw sum falls to nothing there. Without averaging, the flag would flicker on and off as the angle goes round the circle. Averaging over roughly one electrical cycle removes this. Slower rotation calls for a larger shift, which gives a longer time constant.

The detector means something only while the input runs in a three-phase mode. A mode-enable input therefore holds the flag low and empties the filter whenever it is low, which is the case in the two-input orthogonal mode.

Top module: `phase_imbalance_detect`

## Requirements
- R1: While `rst_n` is low, and after it is released, the filter state is zero and `imbalance_flag` is 0.
- R2: The homopolar sum is the two's-complement sum `phase_a + phase_b + phase_c`, computed without overflow. Balanced samples (sum 0) never raise the flag.
- R3: The flag is 1 exactly when |filtered sum| > 3 × `ref_thresh`, a strict comparison. `ref_thresh` is unsigned. A magnitude equal to the trip level gives 0, and a threshold of 0 trips on any nonzero filtered sum.
- R4: The comparison uses the magnitude of the filtered sum, so negative and positive sums of equal size give the same flag.
- R5: While `three_phase_en` is 0, the filter state is cleared and the flag is 0 after the next clock edge. When the enable returns to 1, averaging restarts from zero.
- R6: On each clock edge with `sample_valid` = 1 and `three_phase_en` = 1, the filter state S (the sum scaled by 2^15 when SHIFT_W = 4) is updated as S ← S + ((sum·2^15 − S) >>> `filt_shift`), where >>> is an arithmetic shift. The filtered sum is floor(S / 2^15). A shift of 0 makes the filtered sum equal to the latest sum.
- R7: With `sample_valid` = 0 and the enable set, the filter state holds, and the sample inputs have no effect on the flag.
- R8: The flag is recomputed on every clock edge from the current filter state and the current `ref_thresh`. A threshold change therefore acts one edge later, without a new sample.
- R9: The flag is registered. A sample accepted at edge N updates the filter at edge N, and its effect on the flag appears at edge N+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the system |
| sample_valid | input | 1 | Accept the phase samples on this edge |
| three_phase_en | input | 1 | High in three-phase input modes; low gates the detector off |
| phase_a | input | SAMPLE_W | Signed first phase sample |
| phase_b | input | SAMPLE_W | Signed second phase sample |
| phase_c | input | SAMPLE_W | Signed third phase sample |
| ref_thresh | input | THR_W | Unsigned reference threshold; the trip level is three times this value |
| filt_shift | input | SHIFT_W | Filter coefficient as a right-shift count (0 = no averaging) |
| imbalance_flag | output | 1 | Registered imbalance indication |

## Verification
Each accepted sample lands in the filter at the edge that takes it. The flag follows one edge later, so a sample's result is due two edges after the inputs are driven. The bench drives on the falling edge and samples the flag on the falling edge after the second rising edge. Threshold and enable changes act on the flag at the first rising edge, and they are checked after exactly one edge. A directed test checks the flag between the two edges to confirm the one-edge lag. For filtered runs, the bench steps its own model of the update formula once per sample. It compares the flag after every step.

// File: rtl/imb_pkg.sv
package imb_pkg;
  typedef enum logic [1:0] {
    FILT_HOLD  = 2'd0,
    FILT_CLEAR = 2'd1,
    FILT_STEP  = 2'd2
  } filt_op_e;
endpackage

// File: rtl/imb_phase_sum.sv
module imb_phase_sum #(
  parameter int N_PH     = 3,
  parameter int SAMPLE_W = 16,
  parameter int SUM_W    = SAMPLE_W + $clog2(N_PH) + 1
) (
  input  logic signed [SAMPLE_W-1:0] samples [N_PH],
  output logic signed [SUM_W-1:0]    sum
);
  localparam int EXT_W = SUM_W - SAMPLE_W;

  logic signed [SUM_W-1:0] part [N_PH+1];

  assign part[0] = '0;

  // Running sum of the sign-extended phases, one adder per phase.
  for (genvar g = 0; g < N_PH; g++) begin : g_acc
    logic signed [SUM_W-1:0] ext;
    assign ext         = $signed({{EXT_W{samples[g][SAMPLE_W-1]}}, samples[g]});
    assign part[g + 1] = part[g] + ext;
  end

  assign sum = part[N_PH];
endmodule

// File: rtl/imb_iir_avg.sv
module imb_iir_avg
  import imb_pkg::*;
#(
  parameter int SUM_W   = 18,
  parameter int SHIFT_W = 4,
  parameter int FRAC_W  = (1 << SHIFT_W) - 1,
  parameter int ACC_W   = SUM_W + FRAC_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     enable,
  input  logic                     step,
  input  logic [SHIFT_W-1:0]       shift_k,
  input  logic signed [SUM_W-1:0]  sum_in,
  output logic signed [ACC_W-1:0]  state,
  output logic signed [SUM_W-1:0]  filt_int
);
  localparam int DIFF_W = ACC_W + 1;

  filt_op_e                 op;
  logic signed [ACC_W-1:0]  target;
  logic signed [DIFF_W-1:0] diff;
  logic signed [DIFF_W-1:0] inc;
  logic signed [ACC_W-1:0]  state_d;

  always_comb begin
    if (!enable)   op = FILT_CLEAR;
    else if (step) op = FILT_STEP;
    else           op = FILT_HOLD;
  end

  // The step moves the state toward the scaled input by 2^-k of the gap.
  always_comb begin
    target = $signed({sum_in, {FRAC_W{1'b0}}});
    diff   = $signed({target[ACC_W-1], target}) - $signed({state[ACC_W-1], state});
    inc    = diff >>> shift_k;
    case (op)
      FILT_CLEAR: state_d = '0;
      FILT_STEP:  state_d = state + inc[ACC_W-1:0];
      default:    state_d = state;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= '0;
    else        state <= state_d;
  end

  assign filt_int = state[ACC_W-1:FRAC_W];
endmodule

// File: rtl/imb_trip_cmp.sv
module imb_trip_cmp #(
  parameter int SUM_W = 18,
  parameter int THR_W = 16
) (
  input  logic signed [SUM_W-1:0] value,
  input  logic [THR_W-1:0]        thresh,
  output logic                    over
);
  localparam int TRIP_W = THR_W + 2;
  localparam int CMP_W  = (SUM_W > TRIP_W) ? SUM_W : TRIP_W;

  logic [SUM_W-1:0]  mag;
  logic [TRIP_W-1:0] trip;
  logic [CMP_W-1:0]  mag_x;
  logic [CMP_W-1:0]  trip_x;

  always_comb begin
    mag    = value[SUM_W-1] ? (~value + 1'b1) : value;
    trip   = {2'b00, thresh} + {1'b0, thresh, 1'b0};
    mag_x  = CMP_W'(mag);
    trip_x = CMP_W'(trip);
    over   = mag_x > trip_x;
  end
endmodule

// File: rtl/phase_imbalance_detect.sv
module phase_imbalance_detect #(
  parameter int SAMPLE_W = 16,
  parameter int THR_W    = 16,
  parameter int SHIFT_W  = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sample_valid,
  input  logic                       three_phase_en,
  input  logic signed [SAMPLE_W-1:0] phase_a,
  input  logic signed [SAMPLE_W-1:0] phase_b,
  input  logic signed [SAMPLE_W-1:0] phase_c,
  input  logic [THR_W-1:0]           ref_thresh,
  input  logic [SHIFT_W-1:0]         filt_shift,
  output logic                       imbalance_flag
);
  localparam int N_PH   = 3;
  localparam int SUM_W  = SAMPLE_W + $clog2(N_PH) + 1;
  localparam int FRAC_W = (1 << SHIFT_W) - 1;
  localparam int ACC_W  = SUM_W + FRAC_W;

  logic signed [SAMPLE_W-1:0] ph_vec [N_PH];
  logic signed [SUM_W-1:0]    homo_sum;
  logic signed [ACC_W-1:0]    acc_state;
  logic signed [SUM_W-1:0]    avg_sum;
  logic                       over_trip;
  logic                       flag_d;

  assign ph_vec[0] = phase_a;
  assign ph_vec[1] = phase_b;
  assign ph_vec[2] = phase_c;

  imb_phase_sum #(
    .N_PH(N_PH), .SAMPLE_W(SAMPLE_W), .SUM_W(SUM_W)
  ) u_sum (
    .samples(ph_vec),
    .sum    (homo_sum)
  );

  imb_iir_avg #(
    .SUM_W(SUM_W), .SHIFT_W(SHIFT_W), .FRAC_W(FRAC_W), .ACC_W(ACC_W)
  ) u_avg (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (three_phase_en),
    .step    (sample_valid),
    .shift_k (filt_shift),
    .sum_in  (homo_sum),
    .state   (acc_state),
    .filt_int(avg_sum)
  );

  imb_trip_cmp #(
    .SUM_W(SUM_W), .THR_W(THR_W)
  ) u_cmp (
    .value (avg_sum),
    .thresh(ref_thresh),
    .over  (over_trip)
  );

  always_comb flag_d = three_phase_en & over_trip;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) imbalance_flag <= 1'b0;
    else        imbalance_flag <= flag_d;
  end
endmodule

// File: rtl/imb_checker.sv
module imb_checker #(
  parameter int SUM_W  = 18,
  parameter int THR_W  = 16,
  parameter int FRAC_W = 15,
  parameter int ACC_W  = 33
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    sample_valid,
  input logic                    three_phase_en,
  input logic [THR_W-1:0]        ref_thresh,
  input logic signed [ACC_W-1:0] filt_state,
  input logic                    imbalance_flag
);
  localparam int W = ACC_W + 2;

  logic signed [W-1:0] int_part;
  logic [W-1:0]        mag_chk;
  logic [W-1:0]        trip_chk;
  logic                exceeds;

  always_comb begin
    int_part = W'(filt_state >>> FRAC_W);
    mag_chk  = int_part[W-1] ? W'(-int_part) : W'(int_part);
    trip_chk = W'(ref_thresh) * W'(3);
    exceeds  = mag_chk > trip_chk;
  end

  // R1: no unknown flag once out of reset
  a_r1_flag_known: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown(imbalance_flag));

  // R5: disabled detector drops the flag and empties the filter
  a_r5_gate_flag: assert property (@(posedge clk) disable iff (!rst_n)
    !three_phase_en |=> !imbalance_flag);
  a_r5_gate_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !three_phase_en |=> (filt_state == '0));

  // R7: no sample, no movement of the filter
  a_r7_state_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (three_phase_en && !sample_valid) |=> $stable(filt_state));

  // R3, R9: flag follows the state comparison one edge later
  a_r3_trip_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (three_phase_en && exceeds) |=> imbalance_flag);
  a_r9_flag_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !(three_phase_en && exceeds) |=> !imbalance_flag);
endmodule

bind phase_imbalance_detect imb_checker #(
  .SUM_W(SUM_W), .THR_W(THR_W), .FRAC_W(FRAC_W), .ACC_W(ACC_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .sample_valid  (sample_valid),
  .three_phase_en(three_phase_en),
  .ref_thresh    (ref_thresh),
  .filt_state    (acc_state),
  .imbalance_flag(imbalance_flag)
);

// File: tb/phase_imbalance_detect_test.sv
`timescale 1ns/1ps
module phase_imbalance_detect_test;
  localparam int NV = 11;
  // a, b, c, thresh, expected flag (shift 0: filtered sum equals sum)
  localparam int VEC [NV][5] = '{
    '{1000, -500, -500, 100, 0},        // R2 balanced
    '{200, 50, 50, 100, 0},             // R3 equal to trip
    '{200, 50, 51, 100, 1},             // R3 one above trip
    '{-200, -50, -51, 100, 1},          // R4 negative above
    '{-200, -50, -50, 100, 0},          // R4 negative equal
    '{32767, 32767, 32767, 65535, 0},   // R2 extreme positive sum
    '{32767, 32767, 32767, 32766, 1},   // R2 no overflow in sum
    '{-32768, -32768, -32768, 32767, 1},// R4 most negative sum
    '{1, 0, 0, 0, 1},                   // R3 zero threshold
    '{0, 0, 0, 0, 0},                   // R3 zero threshold, zero sum
    '{7, -3, -4, 0, 0}                  // R2 balanced, zero threshold
  };

  logic clk = 1'b0;
  logic rst_n;
  logic sample_valid;
  logic three_phase_en;
  logic signed [15:0] phase_a, phase_b, phase_c;
  logic [15:0] ref_thresh;
  logic [3:0]  filt_shift;
  logic imbalance_flag;

  int checks = 0;
  int fails  = 0;
  longint model_acc;

  always #2 clk = ~clk;

  phase_imbalance_detect uut (
    .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid),
    .three_phase_en(three_phase_en), .phase_a(phase_a), .phase_b(phase_b),
    .phase_c(phase_c), .ref_thresh(ref_thresh), .filt_shift(filt_shift),
    .imbalance_flag(imbalance_flag)
  );

  task automatic chk(input logic got, input logic exp, input string req);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: imbalance_flag=%b expected %b", req, got, exp);
    end
  endtask

  // Drive one sample; return at the falling edge where its flag is due.
  task automatic apply(input int a, input int b, input int c);
    @(negedge clk);
    phase_a = 16'(a); phase_b = 16'(b); phase_c = 16'(c);
    sample_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    sample_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic model_step(input int s, input int k, input int thr);
    longint tgt;
    longint q;
    tgt = longint'(s) <<< 15;
    model_acc = model_acc + ((tgt - model_acc) >>> k);
    q = model_acc >>> 15;
    if (q < 0) q = -q;
    return q > 3 * longint'(thr);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic e;
    rst_n = 1'b0; sample_valid = 1'b0; three_phase_en = 1'b1;
    phase_a = '0; phase_b = '0; phase_c = '0;
    ref_thresh = 16'd100; filt_shift = 4'd0;
    repeat (3) @(negedge clk);
    chk(imbalance_flag, 1'b0, "R1 during reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk(imbalance_flag, 1'b0, "R1 after reset");

    // Vector table, no averaging
    for (int i = 0; i < NV; i++) begin
      ref_thresh = 16'(VEC[i][3]);
      apply(VEC[i][0], VEC[i][1], VEC[i][2]);
      chk(imbalance_flag, VEC[i][4][0], $sformatf("R3 vector %0d", i));
    end

    // R9: flag lags the filter by one edge
    ref_thresh = 16'd100;
    apply(0, 0, 0);
    @(negedge clk);
    phase_a = 16'sd400; sample_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    sample_valid = 1'b0;
    chk(imbalance_flag, 1'b0, "R9 not yet after first edge");
    @(posedge clk);
    @(negedge clk);
    chk(imbalance_flag, 1'b1, "R9 set after second edge");

    // R7: inputs ignored without sample_valid
    phase_a = '0; phase_b = '0; phase_c = '0;
    repeat (4) @(negedge clk);
    chk(imbalance_flag, 1'b1, "R7 flag holds while sample_valid low");

    // R8: threshold change acts after one edge
    ref_thresh = 16'd200;
    @(posedge clk);
    @(negedge clk);
    chk(imbalance_flag, 1'b0, "R8 raised threshold clears flag");
    ref_thresh = 16'd100;
    @(posedge clk);
    @(negedge clk);
    chk(imbalance_flag, 1'b1, "R8 lowered threshold sets flag");

    // R5: gating
    three_phase_en = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk(imbalance_flag, 1'b0, "R5 enable low drops flag");
    apply(400, 0, 0);
    chk(imbalance_flag, 1'b0, "R5 sample ignored while disabled");
    three_phase_en = 1'b1;
    filt_shift = 4'd15;
    apply(301, 0, 0);
    chk(imbalance_flag, 1'b0, "R5 filter restarted from zero");

    // R6: step response with shift 2
    three_phase_en = 1'b0;
    @(negedge clk);
    three_phase_en = 1'b1;
    filt_shift = 4'd2;
    model_acc = 0;
    for (int n = 0; n < 6; n++) begin
      e = model_step(1200, 2, 100);
      apply(1200, 0, 0);
      chk(imbalance_flag, e, $sformatf("R6 step response sample %0d", n));
    end

    // R6: alternating residue averages out under shift 4
    three_phase_en = 1'b0;
    @(negedge clk);
    three_phase_en = 1'b1;
    filt_shift = 4'd4;
    model_acc = 0;
    for (int n = 0; n < 8; n++) begin
      int s;
      s = (n % 2 == 0) ? 600 : -600;
      e = model_step(s, 4, 100);
      apply(s, 0, 0);
      chk(imbalance_flag, e, $sformatf("R6 alternating sample %0d", n));
    end

    // R1: reset mid-run clears the flag
    filt_shift = 4'd0;
    apply(1000, 0, 0);
    chk(imbalance_flag, 1'b1, "R3 tripped before reset");
    rst_n = 1'b0;
    @(negedge clk);
    chk(imbalance_flag, 1'b0, "R1 reset clears flag");
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(imbalance_flag, 1'b0, "R1 filter cleared by reset");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule